// File: doc/BRIEF.md
# Authenticator Cipher Input Sequencer

This block schedules one mutual-authentication run of a stream cipher that takes one input byte and produces one keystream nibble per tick. A start strobe latches the 8-byte device nonce and the 8-byte key and asks the cipher core to clear its state. The block then steps through a fixed 142-tick schedule. On each tick it presents an input byte to the core and steers the nibble the core returns into one of three result registers: the host authenticator, the device authenticator, or the session key.

Host-nonce bytes come in over a byte-valid handshake while the run is in progress. The sequencer stalls on each host slot until the byte is valid. As a result the cipher work overlaps with reception of the host's message. A mismatch flag from an external comparator ends the run before the session-key ticks and wipes the session key. The cipher state update and the serial link sit outside this block.

Top module: `auth_input_sequencer`

## Requirements
- R1: After reset the following are all zero: busy, done, cipherTick, hostTake, hostAuth, devAuth and sessKey.
- R2: When start is seen while idle, cipherClear is high in that same cycle, devNonce and authKey are latched, and busy rises with tick index 0. A start seen while busy has no effect on the byte stream.
- R3: Tick t below 56 with t mod 7 not equal to 6 is an absorb tick. Let row = t/7 and half = 1 when (t mod 7) ≥ 3, else 0. The tick feeds byte index 2·(row mod 4)+half, where byte i is bits [8i+7:8i]. The byte comes from the latched device nonce for rows 0–3 and from the latched key for rows 4–7. Each byte is therefore fed on three consecutive ticks.
- R4: Tick t = 7·r+6 (r = 0..7) is a host slot. It feeds hostByte, fires only in a cycle where hostByteValid is high, and flags consumption of the byte on hostTake. Otherwise the run stalls on that slot.
- R5: Ticks 56 to 141 feed the byte 0x00.
- R6: Any tick that is not stalled on a host slot fires in every cycle where tickEn is high, and never in a cycle where tickEn is low. With tickEn and hostByteValid held high, a run takes exactly 142 busy cycles.
- R7: The keystream nibble of tick 56+k (k = 0..15) goes into hostAuth bits [4k+3:4k]. The nibble of tick 112+k (k = 0..13) goes into devAuth bits [4k+3:4k]. All other nibbles before tick 126 are discarded.
- R8: The keystream nibble of tick 126+k (k = 0..15) goes into sessKey bits [4k+3:4k].
- R9: done is a one-cycle pulse in the cycle after tick 141 fires, and busy is low in that cycle.
- R10: If authFail is high while busy and the tick index is below 126, the run ends in the next cycle with no done and sessKey cleared to zero. authFail at tick 126 or later has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| devNonce | input | 64 | Device nonce, byte i in bits [8i+7:8i] |
| authKey | input | 64 | Shared key, byte i in bits [8i+7:8i] |
| tickEn | input | 1 | Permission for the cipher to tick this cycle |
| hostByte | input | 8 | Next host-nonce byte |
| hostByteValid | input | 1 | hostByte holds a valid byte |
| hostTake | output | 1 | hostByte consumed this cycle |
| authFail | input | 1 | Host authenticator mismatch from comparator |
| coreNib | input | 4 | Keystream nibble the core returns for the current tick |
| cipherClear | output | 1 | Clear the cipher core state |
| cipherTick | output | 1 | Core advances one tick this cycle |
| cipherByte | output | 8 | Input byte for the current tick |
| hostAuth | output | 64 | Captured host authenticator |
| devAuth | output | 56 | Captured device authenticator |
| sessKey | output | 64 | Captured session key |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed pulse |

## Verification
The hardest situations to reach are a mismatch arriving on a chosen tick and a stall on a host slot that overlaps a cycle without tickEn. Both depend on knowing the tick index, which the ports do not show. The bench models the cipher core with its own tick counter and derives the keystream nibble from that counter and the presented byte. It raises authFail on an exact tick value, both just before and just after the session-key boundary. It also staggers the valid and enable patterns so that host-slot stalls and disabled cycles fall on different ticks.

// File: rtl/authseq_pkg.sv
package authseq_pkg;
  localparam int BYTE_W      = 8;
  localparam int NIB_W       = 4;
  localparam int WORD_BYTES  = 8;
  localparam int WORD_W      = WORD_BYTES * BYTE_W;
  localparam int ROW_LEN     = 7;
  localparam int ABSORB_TICKS = 56;
  localparam int HA_NIBS     = 16;
  localparam int DA_NIBS     = 14;
  localparam int SK_NIBS     = 16;
  localparam int RUN_TICKS   = 142;
  localparam int TICK_W      = $clog2(RUN_TICKS);

  typedef logic [TICK_W-1:0] tick_t;

  localparam tick_t ABSORB_END = tick_t'(ABSORB_TICKS);
  localparam tick_t LAST_TICK  = tick_t'(RUN_TICKS - 1);
  localparam tick_t SK_BASE    = tick_t'(RUN_TICKS - SK_NIBS);
  localparam tick_t DA_BASE    = tick_t'(RUN_TICKS - SK_NIBS - DA_NIBS);
  localparam tick_t HA_BASE    = ABSORB_END;

  typedef struct packed {
    logic  load;
    logic  tick;
    logic  abort;
    tick_t idx;
  } seqCtl_t;
endpackage

// File: rtl/authseq_ctrl.sv
module authseq_ctrl
  import authseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    tickEn,
  input  logic    hostByteValid,
  input  logic    authFail,
  output seqCtl_t ctl,
  output logic    hostTake,
  output logic    busy,
  output logic    done
);
  logic  running;
  tick_t tickIdx;
  logic  hostSlot, abortNow, fire, loadNow;

  always_comb begin
    hostSlot = (tickIdx < ABSORB_END) &&
               ((tickIdx % tick_t'(ROW_LEN)) == tick_t'(ROW_LEN - 1));
    abortNow = running && authFail && (tickIdx < SK_BASE);
    fire     = running && tickEn && (!hostSlot || hostByteValid) && !abortNow;
    loadNow  = !running && start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      tickIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (loadNow) begin
        running <= 1'b1;
        tickIdx <= '0;
      end else if (abortNow) begin
        running <= 1'b0;
      end else if (fire) begin
        if (tickIdx == LAST_TICK) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          tickIdx <= tickIdx + tick_t'(1);
        end
      end
    end
  end

  always_comb begin
    ctl.load  = loadNow;
    ctl.tick  = fire;
    ctl.abort = abortNow;
    ctl.idx   = tickIdx;
    hostTake  = fire && hostSlot;
    busy      = running;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_take_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    hostTake |-> (hostByteValid && tickEn));
  assert_tick_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tick |-> (tickEn && busy));
  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tick && ctl.idx != LAST_TICK) |=> (ctl.idx == ($past(ctl.idx) + tick_t'(1))));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && ctl.idx == '0));
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && authFail && ctl.idx < SK_BASE) |=> (!busy && !done));
endmodule

// File: rtl/authseq_nibpack.sv
module authseq_nibpack
  import authseq_pkg::*;
#(
  parameter int    NIBS = 16,
  parameter tick_t BASE = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clr,
  input  logic                  tick,
  input  tick_t                 idx,
  input  logic [NIB_W-1:0]      nib,
  output logic [NIBS*NIB_W-1:0] q
);
  localparam int    OFF_W   = $clog2(NIBS);
  localparam tick_t END_IDX = tick_t'(int'(BASE) + NIBS);

  logic             inWin;
  logic [OFF_W-1:0] slot;

  always_comb begin
    inWin = tick && (idx >= BASE) && (idx < END_IDX);
    slot  = OFF_W'(idx - BASE);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      q <= '0;
    end else if (inWin) begin
      for (int g = 0; g < NIBS; g++)
        if (slot == OFF_W'(g)) q[g*NIB_W +: NIB_W] <= nib;
    end
  end
endmodule

// File: rtl/authseq_dpath.sv
module authseq_dpath
  import authseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  seqCtl_t                ctl,
  input  logic [WORD_W-1:0]      devNonce,
  input  logic [WORD_W-1:0]      authKey,
  input  logic [BYTE_W-1:0]      hostByte,
  input  logic [NIB_W-1:0]       coreNib,
  output logic [BYTE_W-1:0]      cipherByte,
  output logic [HA_NIBS*NIB_W-1:0] hostAuth,
  output logic [DA_NIBS*NIB_W-1:0] devAuth,
  output logic [SK_NIBS*NIB_W-1:0] sessKey
);
  localparam logic [2:0] HOST_POS = 3'(ROW_LEN - 1);
  localparam logic [2:0] HALF_POS = 3'(ROW_LEN / 2);

  logic [WORD_W-1:0] dnReg, keyReg, srcWord;
  logic [2:0]        row, pos, sel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dnReg  <= '0;
      keyReg <= '0;
    end else if (ctl.load) begin
      dnReg  <= devNonce;
      keyReg <= authKey;
    end
  end

  always_comb begin
    row     = 3'(ctl.idx / tick_t'(ROW_LEN));
    pos     = 3'(ctl.idx % tick_t'(ROW_LEN));
    sel     = {row[1:0], pos >= HALF_POS};
    srcWord = row[2] ? keyReg : dnReg;
    if (ctl.idx >= ABSORB_END)  cipherByte = '0;
    else if (pos == HOST_POS)   cipherByte = hostByte;
    else                        cipherByte = srcWord[{sel, 3'b000} +: BYTE_W];
  end

  authseq_nibpack #(.NIBS(HA_NIBS), .BASE(HA_BASE)) u_ha (
    .clk(clk), .rstN(rstN), .clr(ctl.load), .tick(ctl.tick),
    .idx(ctl.idx), .nib(coreNib), .q(hostAuth));

  authseq_nibpack #(.NIBS(DA_NIBS), .BASE(DA_BASE)) u_da (
    .clk(clk), .rstN(rstN), .clr(ctl.load), .tick(ctl.tick),
    .idx(ctl.idx), .nib(coreNib), .q(devAuth));

  authseq_nibpack #(.NIBS(SK_NIBS), .BASE(SK_BASE)) u_sk (
    .clk(clk), .rstN(rstN), .clr(ctl.abort), .tick(ctl.tick),
    .idx(ctl.idx), .nib(coreNib), .q(sessKey));

  assert_abort_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abort |=> (sessKey == '0));
  assert_zero_tail_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tick && ctl.idx >= ABSORB_END) |-> (cipherByte == '0));
  assert_ha_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.tick && !ctl.load) |=> $stable(hostAuth));
  assert_sk_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.tick && !ctl.abort) |=> $stable(sessKey));
endmodule

// File: rtl/auth_input_sequencer.sv
module auth_input_sequencer
  import authseq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [WORD_W-1:0]        devNonce,
  input  logic [WORD_W-1:0]        authKey,
  input  logic                     tickEn,
  input  logic [BYTE_W-1:0]        hostByte,
  input  logic                     hostByteValid,
  output logic                     hostTake,
  input  logic                     authFail,
  input  logic [NIB_W-1:0]         coreNib,
  output logic                     cipherClear,
  output logic                     cipherTick,
  output logic [BYTE_W-1:0]        cipherByte,
  output logic [HA_NIBS*NIB_W-1:0] hostAuth,
  output logic [DA_NIBS*NIB_W-1:0] devAuth,
  output logic [SK_NIBS*NIB_W-1:0] sessKey,
  output logic                     busy,
  output logic                     done
);
  seqCtl_t ctl;

  authseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tickEn(tickEn),
    .hostByteValid(hostByteValid), .authFail(authFail), .ctl(ctl),
    .hostTake(hostTake), .busy(busy), .done(done));

  authseq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .devNonce(devNonce),
    .authKey(authKey), .hostByte(hostByte), .coreNib(coreNib),
    .cipherByte(cipherByte), .hostAuth(hostAuth), .devAuth(devAuth),
    .sessKey(sessKey));

  assign cipherClear = ctl.load;
  assign cipherTick  = ctl.tick;
endmodule

// File: tb/auth_input_sequencer_tb.sv
`timescale 1ns/1ps
module auth_input_sequencer_tb;
  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [63:0] devNonce = '0, authKey = '0;
  logic        tickEn = 1'b0, hostByteValid = 1'b0, authFail = 1'b0;
  logic [7:0]  hostByte = '0;
  logic [3:0]  coreNib;
  logic        hostTake, cipherClear, cipherTick, busy, done;
  logic [7:0]  cipherByte;
  logic [63:0] hostAuth, sessKey;
  logic [55:0] devAuth;

  int total = 0, bad = 0;
  int tbCnt = 0;

  always #2.5 clk = ~clk;

  auth_input_sequencer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .devNonce(devNonce),
    .authKey(authKey), .tickEn(tickEn), .hostByte(hostByte),
    .hostByteValid(hostByteValid), .hostTake(hostTake), .authFail(authFail),
    .coreNib(coreNib), .cipherClear(cipherClear), .cipherTick(cipherTick),
    .cipherByte(cipherByte), .hostAuth(hostAuth), .devAuth(devAuth),
    .sessKey(sessKey), .busy(busy), .done(done));

  function automatic logic [3:0] nibFn(input logic [7:0] b, input int c);
    logic [7:0] cc = 8'(c);
    return b[3:0] ^ b[7:4] ^ cc[3:0] ^ cc[7:4] ^ 4'h5;
  endfunction

  assign coreNib = nibFn(cipherByte, tbCnt);

  always @(posedge clk) begin
    if (cipherClear) tbCnt <= 0;
    else if (cipherTick) tbCnt <= tbCnt + 1;
  end

  function automatic logic [7:0] expByte(input int t, input logic [63:0] dn, k, hn);
    int r, p, i;
    if (t >= 56) return 8'h00;
    r = t / 7; p = t % 7;
    if (p == 6) return hn[8*r +: 8];
    i = 2 * (r % 4) + ((p >= 3) ? 1 : 0);
    return (r < 4) ? dn[8*i +: 8] : k[8*i +: 8];
  endfunction

  function automatic logic [63:0] expHa();
    logic [63:0] v = '0;
    for (int k = 0; k < 16; k++) v[4*k +: 4] = nibFn(8'h00, 56 + k);
    return v;
  endfunction
  function automatic logic [55:0] expDa();
    logic [55:0] v = '0;
    for (int k = 0; k < 14; k++) v[4*k +: 4] = nibFn(8'h00, 112 + k);
    return v;
  endfunction
  function automatic logic [63:0] expSk();
    logic [63:0] v = '0;
    for (int k = 0; k < 16; k++) v[4*k +: 4] = nibFn(8'h00, 126 + k);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [63:0] dn;
    logic [63:0] k;
    logic [63:0] hn;
    logic [1:0]  mode;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{dn: 64'h0706050403020100, k: 64'hF7E6D5C4B3A29180, hn: 64'h1122334455667788, mode: 2'd0},
    '{dn: 64'hDEADBEEFCAFEF00D, k: 64'h0123456789ABCDEF, hn: 64'hA5A55A5A0FF0F00F, mode: 2'd1},
    '{dn: 64'h8000000000000001, k: 64'hFFFFFFFFFFFFFFFF, hn: 64'h0000000000000000, mode: 2'd2},
    '{dn: 64'h13579BDF2468ACE0, k: 64'h55AA55AA33CC33CC, hn: 64'hFEDCBA9876543210, mode: 2'd3}
  };

  int  rTicks, rByteErr, rBusy, rEnErr;
  bit  rDone, rClear;

  task automatic doRun(input logic [63:0] dn, k, hn, input logic [1:0] mode,
                       input int abortAt, input int failFrom, input int restartAt);
    int hostIdx = 0;
    rTicks = 0; rByteErr = 0; rBusy = 0; rEnErr = 0; rDone = 0;
    @(negedge clk);
    devNonce = dn; authKey = k; start = 1'b1;
    #1 rClear = cipherClear;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      tickEn        = mode[1] ? ((cyc % 3) != 1) : 1'b1;
      hostByteValid = mode[0] ? ((cyc % 4) == 3) : 1'b1;
      hostByte      = (hostIdx < 8) ? hn[8*hostIdx +: 8] : 8'h00;
      authFail      = ((abortAt >= 0) && (tbCnt == abortAt)) ||
                      ((failFrom >= 0) && (tbCnt >= failFrom));
      if ((restartAt >= 0) && (tbCnt == restartAt)) begin
        start = 1'b1; devNonce = ~dn; authKey = ~k;
      end else begin
        start = 1'b0;
      end
      #1;
      if (done) rDone = 1'b1;
      if (!busy) break;
      rBusy++;
      if (cipherTick) begin
        rTicks++;
        if (!tickEn) rEnErr++;
        if (cipherByte !== expByte(tbCnt, dn, k, hn)) begin
          rByteErr++;
          if (rByteErr == 1)
            $display("FAIL R3/R4/R5 byte at tick %0d: actual=%h expected=%h",
                     tbCnt, cipherByte, expByte(tbCnt, dn, k, hn));
        end
        if (hostTake) hostIdx++;
      end else if (tickEn && !authFail && !(tbCnt < 56 && tbCnt % 7 == 6)) begin
        rEnErr++;
      end
      @(negedge clk);
    end
    start = 1'b0; authFail = 1'b0; tickEn = 1'b0; hostByteValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", 64'(busy), 0);
    chk(done == 1'b0 && cipherTick == 1'b0 && hostTake == 1'b0, "R1", "done/tick/take",
        {61'd0, done, cipherTick, hostTake}, 0);
    chk(hostAuth == 0 && devAuth == 0 && sessKey == 0, "R1", "result regs",
        hostAuth | sessKey | 64'(devAuth), 0);

    // main table
    foreach (VECS[v]) begin
      doRun(VECS[v].dn, VECS[v].k, VECS[v].hn, VECS[v].mode, -1, -1, -1);
      chk(rClear, "R2", "cipherClear on start", 64'(rClear), 1);
      chk(rByteErr == 0, "R3", "absorb/host/zero byte stream errors", 64'(rByteErr), 0);
      chk(rTicks == 142, "R6", "tick count", 64'(rTicks), 142);
      chk(rEnErr == 0, "R6", "tick vs enable errors", 64'(rEnErr), 0);
      if (VECS[v].mode == 2'd0)
        chk(rBusy == 142, "R6", "busy cycles unstalled", 64'(rBusy), 142);
      chk(hostAuth == expHa(), "R7", "hostAuth", hostAuth, expHa());
      chk(devAuth == expDa(), "R7", "devAuth", 64'(devAuth), 64'(expDa()));
      chk(sessKey == expSk(), "R8", "sessKey", sessKey, expSk());
      chk(rDone, "R9", "done seen", 64'(rDone), 1);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", {62'd0, done, busy}, 0);
    end

    // R10: abort at tick 30 after a good run left a nonzero key
    doRun(VECS[0].dn, VECS[0].k, VECS[0].hn, 2'd0, 30, -1, -1);
    chk(rDone == 1'b0, "R10", "no done after abort", 64'(rDone), 0);
    chk(sessKey == 0, "R10", "sessKey cleared", sessKey, 0);
    chk(rTicks == 30, "R10", "ticks before abort", 64'(rTicks), 30);

    // R10: abort just before boundary (tick 125)
    doRun(VECS[1].dn, VECS[1].k, VECS[1].hn, 2'd0, 125, -1, -1);
    chk(rDone == 1'b0 && rTicks == 125, "R10", "abort at 125", 64'(rTicks), 125);

    // R10: authFail from tick 126 onward ignored
    doRun(VECS[2].dn, VECS[2].k, VECS[2].hn, 2'd0, -1, 126, -1);
    chk(rDone, "R10", "late fail ignored, done", 64'(rDone), 1);
    chk(sessKey == expSk(), "R10", "late fail key intact", sessKey, expSk());

    // R2: start while busy ignored
    doRun(VECS[3].dn, VECS[3].k, VECS[3].hn, 2'd3, -1, -1, 20);
    chk(rByteErr == 0, "R2", "restart mid-run ignored", 64'(rByteErr), 0);
    chk(rTicks == 142 && rDone, "R2", "restart run length", 64'(rTicks), 142);

    // R4: host slot stalls with valid low
    @(negedge clk);
    devNonce = VECS[0].dn; authKey = VECS[0].k; start = 1'b1;
    @(negedge clk);
    start = 1'b0; tickEn = 1'b1; hostByteValid = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    chk(cipherTick == 1'b0 && hostTake == 1'b0 && tbCnt == 6, "R4", "stall at host slot",
        64'(tbCnt), 6);
    hostByte = 8'h9C; hostByteValid = 1'b1;
    #1;
    chk(hostTake && cipherByte == 8'h9C, "R4", "host byte passes", 64'(cipherByte), 64'h9C);
    @(negedge clk);
    authFail = 1'b1;
    @(negedge clk);
    authFail = 1'b0; tickEn = 1'b0;
    #1 chk(busy == 1'b0, "R10", "stall test abort", 64'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule